// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes eight active-low, level-sensitive PCI interrupt lines (sources A through H) and steers each one onto a 16-line legacy IRQ vector. The legacy interrupt controllers sit downstream of that vector. Every source has its own 8-bit route register. Software writes these registers through a simple address/data port and reads them back combinationally on the same address.

Each source line is inverted to active-high and passes through a two-flop synchronizer. The synchronized line then drives the IRQ chosen by its route register. More than one source may select the same IRQ; that output is the OR of those sources. A source can be switched off entirely. It is also switched off when its route names an IRQ outside the permitted set. Any IRQ that no active route selects is held low.

Top module: `irq_steer_router`

## Requirements
- R1: After reset every route register reads 80h, and irq_out is all zero whatever the source lines do.
- R2: Sources A, B, C and D use the registers at 60h, 61h, 62h and 63h. Sources E, F, G and H use 68h, 69h, 6Ah and 6Bh. A write to any other address changes no register and no output, and a read of any other address returns 00h.
- R3: In a route register, bit 7 = 1 switches the source off. Bits 3:0 hold the target IRQ number. Bits 6:4 are dropped on write and read back as zero.
- R4: The permitted targets are IRQ 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. A source that is switched on, routed to a permitted target and asserted low drives irq_out[target] high.
- R5: A route to IRQ 0, 1, 2, 8 or 13 behaves as switched off. irq_out never drives one of those bits high.
- R6: When several switched-on sources share one target, that output is the OR of their asserted states.
- R7: An irq_out bit that no switched-on, permitted route selects stays low. A switched-off source has no effect on any output.
- R8: A change on a source line reaches irq_out on the second rising clock edge after it is sampled. A route write takes effect on irq_out right after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_n | input | 8 | Active-low PCI interrupt lines, bit 0 = source A |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| irq_out | output | 16 | Active-high legacy IRQ vector |

## Verification
The hardest case to reach from the ports is a route change and a source-line change landing in neighbouring cycles. The output must then reflect the new route together with the source state that is two edges old. Directed steps first pin down each timing relation on its own and sweep all sixteen target codes. A long random phase then mixes writes to both valid and neighbouring invalid addresses with toggling source lines. A behavioural model compares both outputs on every clock throughout.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int TGT_W   = 4;
   localparam int NUM_IRQ = 1 << TGT_W;

   typedef struct packed {
      logic             off;
      logic [TGT_W-1:0] tgt;
   } route_t;

   localparam route_t ROUTE_RST = '{off: 1'b1, tgt: '0};
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;
   logic [1:0]   warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
         warm <= '0;
      end else begin
         meta <= d;
         q    <= meta;
         if (warm != 2'd2) warm <= warm + 2'd1;
      end
   end

   // R8: output equals input from two edges earlier
   p_two_flop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_steer_pkg::*;
#(
   parameter int                NUM_SRC   = 8,
   parameter int                BANK_SIZE = 4,
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter int                OFF_BIT   = 7,
   parameter logic [ADDR_W-1:0] BANK0     = 8'h60,
   parameter logic [ADDR_W-1:0] BANK1     = 8'h68
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output route_t [NUM_SRC-1:0] routes
);
   logic [NUM_SRC-1:0] hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
      localparam logic [ADDR_W-1:0] BASE  = (s < BANK_SIZE) ? BANK0 : BANK1;
      localparam logic [ADDR_W-1:0] MY_AD = BASE + ADDR_W'(s % BANK_SIZE);

      assign hit[s] = (reg_addr == MY_AD);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            routes[s] <= ROUTE_RST;
         else if (wr_en && hit[s])
            routes[s] <= '{off: wr_data[OFF_BIT], tgt: wr_data[TGT_W-1:0]};
      end

      // R3: reserved bits never reach the stored route
      p_rsvd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit[s] && (wr_data[OFF_BIT-1:TGT_W] != '0)) |=>
         (routes[s] == route_t'({$past(wr_data[OFF_BIT]), $past(wr_data[TGT_W-1:0])})));
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (hit[s]) begin
            rd_data[OFF_BIT]     = routes[s].off;
            rd_data[TGT_W-1:0]   = routes[s].tgt;
         end
      end
   end

   // R2: writes to unmapped addresses leave every route unchanged
   p_miss_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (hit == '0)) |=> $stable(routes));

   // R2: at most one register answers an address
   p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
   import irq_steer_pkg::*;
#(
   parameter int                 NUM_SRC    = 8,
   parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8
) (
   input  route_t [NUM_SRC-1:0] routes,
   input  logic   [NUM_SRC-1:0] active,
   output logic   [NUM_IRQ-1:0] irq
);
   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      if (LEGAL_MASK[k]) begin : g_legal
         logic [NUM_SRC-1:0] drive;
         for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign drive[s] = active[s] && !routes[s].off &&
                              (routes[s].tgt == TGT_W'(k));
         end
         assign irq[k] = |drive;
      end else begin : g_tied
         assign irq[k] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
   import irq_steer_pkg::*;
#(
   parameter int                 NUM_SRC    = 8,
   parameter int                 BANK_SIZE  = 4,
   parameter int                 ADDR_W     = 8,
   parameter int                 DATA_W     = 8,
   parameter int                 OFF_BIT    = 7,
   parameter logic [ADDR_W-1:0]  BANK0      = 8'h60,
   parameter logic [ADDR_W-1:0]  BANK1      = 8'h68,
   parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  pirq_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_IRQ-1:0]  irq_out
);
   if (NUM_SRC != 2 * BANK_SIZE) begin : g_bad_banks
      $error("source count must fill both register banks");
   end
   if (OFF_BIT != DATA_W - 1 || OFF_BIT <= TGT_W) begin : g_bad_fields
      $error("switch-off bit must be the top data bit, above the target field");
   end

   route_t [NUM_SRC-1:0] routes;
   logic   [NUM_SRC-1:0] active;

   irq_sync2 #(.W(NUM_SRC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (~pirq_n),
      .q     (active)
   );

   irq_route_regs #(
      .NUM_SRC   (NUM_SRC),
      .BANK_SIZE (BANK_SIZE),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .OFF_BIT   (OFF_BIT),
      .BANK0     (BANK0),
      .BANK1     (BANK1)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .reg_addr (reg_addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .routes   (routes)
   );

   irq_route_matrix #(
      .NUM_SRC    (NUM_SRC),
      .LEGAL_MASK (LEGAL_MASK)
   ) u_matrix (
      .routes (routes),
      .active (active),
      .irq    (irq_out)
   );

   // R5: non-permitted IRQ numbers are never driven
   p_illegal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_out & ~LEGAL_MASK) == '0));

   // R7: with every source switched off, the vector is silent
   p_all_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&{routes[7].off, routes[6].off, routes[5].off, routes[4].off,
         routes[3].off, routes[2].off, routes[1].off, routes[0].off})
      |-> (irq_out == '0));

   // R7: no asserted synchronized source means no IRQ
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active == '0) |-> (irq_out == '0));
endmodule

// File: tb/irq_steer_router_bench.sv
module irq_steer_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pirq_n = 8'h00;
   logic        wr_en = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [15:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_steer_router u_irq_steer_router (
      .clk      (clk),
      .rst_n    (rst_n),
      .pirq_n   (pirq_n),
      .wr_en    (wr_en),
      .reg_addr (reg_addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .irq_out  (irq_out)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_rt [8];
   logic [7:0] m_s1, m_s2;

   function automatic int idx_of(input logic [7:0] a);
      if (a >= 8'h60 && a <= 8'h63) return int'(a - 8'h60);
      if (a >= 8'h68 && a <= 8'h6B) return int'(a - 8'h68) + 4;
      return -1;
   endfunction

   function automatic bit permitted(input int t);
      case (t)
         3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_irq();
      logic [15:0] v = '0;
      for (int s = 0; s < 8; s++)
         if (!m_rt[s][7] && permitted(int'(m_rt[s][3:0])) && m_s2[s])
            v[m_rt[s][3:0]] = 1'b1;
      return v;
   endfunction

   function automatic logic [7:0] exp_rd();
      int i = idx_of(reg_addr);
      return (i < 0) ? 8'h00 : m_rt[i];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_rt[i] = 8'h80;
         m_s1 = '0;
         m_s2 = '0;
      end else begin
         m_s2 = m_s1;
         m_s1 = ~pirq_n;
         if (wr_en && idx_of(reg_addr) >= 0)
            m_rt[idx_of(reg_addr)] = wr_data & 8'h8F;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8 and all others: per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 model irq_out", irq_out, exp_irq());
         chk("R2 model rd_data", {8'h00, rd_data}, {8'h00, exp_rd()});
      end
   end

   // ---------------- helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic smp();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      tick(1);
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] e);
      tick(1);
      reg_addr = a;
      smp();
      chk(tag, {8'h00, rd_data}, {8'h00, e});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      smp();
      chk("R1 irq_out after reset", irq_out, 16'h0000);
      chk("R7 sources asserted but all off", irq_out, 16'h0000);
      rd_chk("R1 reset 60h", 8'h60, 8'h80);
      rd_chk("R1 reset 63h", 8'h63, 8'h80);
      rd_chk("R1 reset 68h", 8'h68, 8'h80);
      rd_chk("R1 reset 6Bh", 8'h6B, 8'h80);

      pirq_n = 8'hFF;
      wr(8'h60, 8'h05);
      wr(8'h61, 8'h08);
      wr(8'h62, 8'h0D);
      wr(8'h63, 8'h00);
      wr(8'h68, 8'h0B);
      wr(8'h69, 8'h0B);
      pirq_n = ~8'b0000_0001;
      tick(3); smp();
      chk("R4 source A to IRQ5", irq_out, 16'h0020);

      pirq_n = ~8'b0000_1110;
      tick(3); smp();
      chk("R5 illegal targets 8,13,0 silent", irq_out, 16'h0000);

      pirq_n = ~8'b0001_0000;
      tick(3); smp();
      chk("R6 E alone on IRQ11", irq_out, 16'h0800);
      pirq_n = ~8'b0010_0000;
      tick(3); smp();
      chk("R6 F alone on IRQ11", irq_out, 16'h0800);
      pirq_n = ~8'b0011_0001;
      tick(3); smp();
      chk("R6 E|F plus A", irq_out, 16'h0820);
      pirq_n = 8'hFF;
      tick(3); smp();
      chk("R6 none asserted", irq_out, 16'h0000);

      wr(8'h6A, 8'hF7);
      rd_chk("R3 reserved bits read zero (off)", 8'h6A, 8'h87);
      pirq_n = ~8'b0100_0000;
      tick(3); smp();
      chk("R3 switched-off G silent", irq_out, 16'h0000);
      wr(8'h6A, 8'h77);
      rd_chk("R3 reserved bits read zero (on)", 8'h6A, 8'h07);
      smp();
      chk("R3 G on to IRQ7", irq_out, 16'h0080);

      // latency of the source path
      pirq_n = 8'hFF;
      tick(3);
      pirq_n = ~8'b0000_0001;
      smp(); smp();
      chk("R8 one edge after change: unchanged", irq_out, 16'h0000);
      smp();
      chk("R8 two edges after change: driven", irq_out, 16'h0020);
      // route write effective right after its edge
      wr(8'h60, 8'h09);
      smp();
      chk("R8 route write immediate", irq_out, 16'h0200);

      // unmapped addresses
      wr(8'h64, 8'h03);
      wr(8'h67, 8'h03);
      wr(8'h6C, 8'h03);
      wr(8'h5F, 8'h03);
      wr(8'h70, 8'h03);
      pirq_n = 8'h00;
      tick(3); smp();
      chk("R2 unmapped writes leave outputs", irq_out, 16'h0A80);
      rd_chk("R2 60h kept", 8'h60, 8'h09);
      rd_chk("R2 61h kept", 8'h61, 8'h08);
      rd_chk("R2 62h kept", 8'h62, 8'h0D);
      rd_chk("R2 63h kept", 8'h63, 8'h00);
      rd_chk("R2 68h kept", 8'h68, 8'h0B);
      rd_chk("R2 69h kept", 8'h69, 8'h0B);
      rd_chk("R2 6Ah kept", 8'h6A, 8'h07);
      rd_chk("R2 6Bh kept", 8'h6B, 8'h80);
      rd_chk("R2 unmapped read 64h", 8'h64, 8'h00);

      // sweep every target code for source A only
      for (int i = 0; i < 8; i++) wr(8'(idx_of(8'h60) + ((i < 4) ? 8'h60 + i : 8'h64 + i) - 8'h60), 8'h80);
      pirq_n = ~8'b0000_0001;
      tick(3);
      for (int t = 0; t < 16; t++) begin
         wr(8'h60, 8'(t));
         smp();
         chk(permitted(t) ? "R4 permitted target sweep" : "R5 non-permitted target sweep",
             irq_out, permitted(t) ? (16'h0001 << t) : 16'h0000);
      end

      // random mix
      for (int c = 0; c < 4000; c++) begin
         tick(1);
         wr_en    = ($urandom_range(0, 3) == 0);
         reg_addr = 8'($urandom_range(8'h5E, 8'h6D));
         wr_data  = 8'($urandom);
         if ($urandom_range(0, 2) == 0) pirq_n = 8'($urandom);
      end
      wr_en = 1'b0;
      tick(3);
      finish_run();
   end
endmodule